// File: doc/BRIEF.md
# XNOR-Feedback PRBS15 Sequence Generator

This block produces a pseudo-random bit stream from a 16-stage shift register. In its main mode the new bit entering stage 1 is the XNOR of stages 14 and 15. Stages 1 to 15 run through all 32767 states except the all-ones pattern. Stage 16 is a one-clock-delayed copy of stage 15. The serial bit is taken from stage 14. The whole register is also brought out so that downstream logic can use any stage as a tap, for example in a weighted-sum filter that turns the bit stream into band-limited noise.

A mode input picks one of two other modes for small-scale checking: a 4-bit maximal-length generator fed back from stages 3 and 4, with either XOR or XNOR feedback. The rest of the chain keeps shifting behind stage 4. If the sequence-forming stages hold the one pattern that would freeze the register for the current mode, a lock flag is raised. The next enabled clock then reloads the mode's start pattern. A period marker pulses once each time the sequence wraps back to its start pattern.

The control path is a small state machine with three states:
- ST_SEEDED: the register holds the start pattern after reset or after a recovery.
- ST_RUNNING: normal shifting, or holding while the enable is low.
- ST_WRAPPED: the last enabled shift landed on the start pattern. This is the state that drives the marker.

Transitions:
- Reset goes to ST_SEEDED from any state.
- Recovery (enabled clock while locked) goes to ST_SEEDED.
- Wrap (enabled shift landing on the start pattern) goes to ST_WRAPPED.
- Advance (any other enabled shift) goes to ST_RUNNING.
- Pause (enable low) keeps ST_SEEDED or ST_RUNNING, and moves ST_WRAPPED to ST_RUNNING.

Top module: `prbs15_xnor_gen`

## Requirements
- R1: A clock edge with `rst_i` high loads the start pattern of the mode on `mode_i`: all zeros for modes 2'b00, 2'b10 and 2'b11, and all ones (16'hFFFF) for mode 2'b01. The same edge clears `period_o`.
- R2: In the long mode (`mode_i` 2'b00 or 2'b11), each enabled, unlocked edge loads stage 1 (`taps_o[0]`) with the XNOR of stage 14 (`taps_o[13]`) and stage 15 (`taps_o[14]`). Every other stage k+1 takes the old value of stage k, so stage 16 (`taps_o[15]`) is a delayed copy of stage 15.
- R3: `prbs_o` always equals stage 14 (`taps_o[13]`).
- R4: In the long mode, starting from reset with the enable held high, stages 1 to 15 first return to all zeros after exactly 32767 enabled edges.
- R5: In the short modes, stage 1 takes the feedback of stages 3 and 4 (`taps_o[2]`, `taps_o[3]`): XOR for `mode_i` 2'b01 and XNOR for 2'b10. The rest of the chain shifts as in R2, and stages 1 to 4 return to the start pattern every 15 enabled edges.
- R6: `lock_o` is high, without waiting for a clock, whenever the sequence-forming stages hold the frozen pattern of the current mode. For the long mode this is stages 1 to 15 all ones. For 2'b01 it is stages 1 to 4 all zeros. For 2'b10 it is stages 1 to 4 all ones.
- R7: An enabled edge while `lock_o` is high reloads the start pattern of the current mode, and `period_o` stays low after it.
- R8: `period_o` is high for exactly the cycle after an enabled, unlocked edge that shifts the sequence-forming stages into the start pattern. It is low at all other times.
- R9: An edge with `en_i` low and `rst_i` low leaves all 16 stages unchanged, and `period_o` is low after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Clock enable for the shift register |
| mode_i | input | 2 | 00/11 long XNOR, 01 short XOR, 10 short XNOR |
| prbs_o | output | 1 | Serial sequence bit (stage 14) |
| taps_o | output | 16 | All stages, bit k-1 is stage k |
| period_o | output | 1 | One-cycle wrap marker |
| lock_o | output | 1 | Frozen pattern present for the current mode |

## Verification
The assertions check on every cycle:
- the shift-and-feedback step in both the long and the short modes;
- holding while the enable is low;
- the reset load;
- that a recovery clears the lock and never raises the marker.

Other behaviour needs whole scenarios from the bench:
- the exact 32767-edge and 15-edge periods;
- the known first states after reset;
- reaching a frozen pattern, which needs a mode switch on top of a start pattern that belongs to another mode.

The random phase mixes enable gaps, mode switches and resets, and compares every cycle against a reference model.

// File: rtl/prbs15_gen_pkg.sv
package prbs15_gen_pkg;

    typedef enum logic [1:0] {
        MODE_LONG      = 2'b00,
        MODE_SHORT_XOR = 2'b01,
        MODE_SHORT_XNR = 2'b10,
        MODE_LONG_ALT  = 2'b11
    } seq_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_SHIFT = 2'b01,
        ACT_LOAD  = 2'b10
    } chain_act_e;

    typedef enum logic [1:0] {
        ST_SEEDED  = 2'b00,
        ST_RUNNING = 2'b01,
        ST_WRAPPED = 2'b10
    } gen_state_e;

endpackage

// File: rtl/prbs_tap_logic.sv
module prbs_tap_logic
    import prbs15_gen_pkg::*;
#(
    parameter int N_STAGES    = 16,
    parameter int LONG_TAP_A  = 14,
    parameter int LONG_TAP_B  = 15,
    parameter int SHORT_TAP_A = 3,
    parameter int SHORT_TAP_B = 4
) (
    input  logic [N_STAGES-1:0] stages_i,
    input  logic [1:0]          mode_i,
    output logic                feedback_o,
    output logic [N_STAGES-1:0] seed_o,
    output logic                frozen_o,
    output logic                lands_o
);

    localparam logic [N_STAGES-1:0] ALL_ONES   = {N_STAGES{1'b1}};
    localparam logic [N_STAGES-1:0] LONG_MASK  = ALL_ONES >> (N_STAGES - LONG_TAP_B);
    localparam logic [N_STAGES-1:0] SHORT_MASK = ALL_ONES >> (N_STAGES - SHORT_TAP_B);

    seq_mode_e             mode;
    logic [N_STAGES-1:0]   mask;
    logic [N_STAGES-1:0]   shifted;

    assign mode = seq_mode_e'(mode_i);

    always_comb begin
        unique case (mode)
            MODE_SHORT_XOR: begin
                feedback_o = stages_i[SHORT_TAP_A-1] ^ stages_i[SHORT_TAP_B-1];
                seed_o     = ALL_ONES;
                mask       = SHORT_MASK;
            end
            MODE_SHORT_XNR: begin
                feedback_o = ~(stages_i[SHORT_TAP_A-1] ^ stages_i[SHORT_TAP_B-1]);
                seed_o     = '0;
                mask       = SHORT_MASK;
            end
            default: begin
                feedback_o = ~(stages_i[LONG_TAP_A-1] ^ stages_i[LONG_TAP_B-1]);
                seed_o     = '0;
                mask       = LONG_MASK;
            end
        endcase
    end

    // The frozen pattern is the bitwise complement of the start pattern
    // over the sequence-forming stages.
    assign shifted  = {stages_i[N_STAGES-2:0], feedback_o};
    assign frozen_o = ((stages_i ^ ~seed_o) & mask) == '0;
    assign lands_o  = ((shifted ^ seed_o) & mask) == '0;

endmodule

// File: rtl/prbs_stage_chain.sv
module prbs_stage_chain
    import prbs15_gen_pkg::*;
#(
    parameter int N_STAGES = 16
) (
    input  logic                clk_i,
    input  chain_act_e          act_i,
    input  logic                feedback_i,
    input  logic [N_STAGES-1:0] seed_i,
    output logic [N_STAGES-1:0] stages_o
);

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        logic d_in;
        logic q;

        if (k == 0) begin : g_head
            assign d_in = feedback_i;
        end else begin : g_body
            assign d_in = stages_o[k-1];
        end

        always_ff @(posedge clk_i) begin
            unique case (act_i)
                ACT_LOAD:  q <= seed_i[k];
                ACT_SHIFT: q <= d_in;
                default:   q <= q;
            endcase
        end

        assign stages_o[k] = q;
    end

endmodule

// File: rtl/prbs_seq_ctrl.sv
module prbs_seq_ctrl
    import prbs15_gen_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       frozen_i,
    input  logic       lands_i,
    output chain_act_e act_o,
    output logic       wrap_o
);

    gen_state_e state_q;
    gen_state_e state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (rst_i) begin
            state_d = ST_SEEDED;
        end else if (en_i) begin
            if (frozen_i)     state_d = ST_SEEDED;
            else if (lands_i) state_d = ST_WRAPPED;
            else              state_d = ST_RUNNING;
        end else begin
            unique case (state_q)
                ST_SEEDED:  state_d = ST_SEEDED;
                ST_RUNNING: state_d = ST_RUNNING;
                ST_WRAPPED: state_d = ST_RUNNING;
                default:    state_d = ST_SEEDED;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        if (rst_i)                 act_o = ACT_LOAD;
        else if (en_i && frozen_i) act_o = ACT_LOAD;
        else if (en_i)             act_o = ACT_SHIFT;
        else                       act_o = ACT_HOLD;
        unique case (state_q)
            ST_WRAPPED: wrap_o = 1'b1;
            default:    wrap_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/prbs15_xnor_gen.sv
module prbs15_xnor_gen
    import prbs15_gen_pkg::*;
#(
    parameter int N_STAGES    = 16,
    parameter int LONG_TAP_A  = 14,
    parameter int LONG_TAP_B  = 15,
    parameter int SHORT_TAP_A = 3,
    parameter int SHORT_TAP_B = 4,
    parameter int OUT_STAGE   = 14
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    input  logic [1:0]          mode_i,
    output logic                prbs_o,
    output logic [N_STAGES-1:0] taps_o,
    output logic                period_o,
    output logic                lock_o
);

    logic                feedback;
    logic [N_STAGES-1:0] seed;
    logic                frozen;
    logic                lands;
    chain_act_e          act;
    logic [N_STAGES-1:0] stages;

    prbs_tap_logic #(
        .N_STAGES    (N_STAGES),
        .LONG_TAP_A  (LONG_TAP_A),
        .LONG_TAP_B  (LONG_TAP_B),
        .SHORT_TAP_A (SHORT_TAP_A),
        .SHORT_TAP_B (SHORT_TAP_B)
    ) u_taps (
        .stages_i   (stages),
        .mode_i     (mode_i),
        .feedback_o (feedback),
        .seed_o     (seed),
        .frozen_o   (frozen),
        .lands_o    (lands)
    );

    prbs_seq_ctrl u_ctrl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .frozen_i (frozen),
        .lands_i  (lands),
        .act_o    (act),
        .wrap_o   (period_o)
    );

    prbs_stage_chain #(
        .N_STAGES (N_STAGES)
    ) u_chain (
        .clk_i      (clk_i),
        .act_i      (act),
        .feedback_i (feedback),
        .seed_i     (seed),
        .stages_o   (stages)
    );

    assign taps_o = stages;
    assign prbs_o = stages[OUT_STAGE-1];
    assign lock_o = frozen;

endmodule

// File: rtl/prbs15_xnor_gen_chk.sv
module prbs15_xnor_gen_chk #(
    parameter int N_STAGES    = 16,
    parameter int LONG_TAP_A  = 14,
    parameter int LONG_TAP_B  = 15,
    parameter int SHORT_TAP_A = 3,
    parameter int SHORT_TAP_B = 4
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                en_i,
    input logic [1:0]          mode_i,
    input logic [N_STAGES-1:0] taps_o,
    input logic                period_o,
    input logic                lock_o
);

    assert_reset_seed_R1: assert property (@(posedge clk_i)
        rst_i |=> (!period_o &&
                   taps_o == (($past(mode_i) == 2'b01) ? {N_STAGES{1'b1}} : {N_STAGES{1'b0}})));

    assert_long_shift_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !lock_o && (mode_i[0] == mode_i[1])) |=>
        (taps_o == {$past(taps_o[N_STAGES-2:0]),
                    ~($past(taps_o[LONG_TAP_A-1]) ^ $past(taps_o[LONG_TAP_B-1]))}));

    assert_short_shift_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && !lock_o && (mode_i[0] != mode_i[1])) |=>
        (taps_o[N_STAGES-1:1] == $past(taps_o[N_STAGES-2:0]) &&
         taps_o[0] == ($past(taps_o[SHORT_TAP_A-1]) ^ $past(taps_o[SHORT_TAP_B-1]) ^ $past(mode_i[1]))));

    assert_recover_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && lock_o) |=> (!period_o && (!$stable(mode_i) || !lock_o)));

    assert_mark_unlocked_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (period_o && $stable(mode_i)) |-> !lock_o);

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ($stable(taps_o) && !period_o));

endmodule

bind prbs15_xnor_gen prbs15_xnor_gen_chk #(
    .N_STAGES    (N_STAGES),
    .LONG_TAP_A  (LONG_TAP_A),
    .LONG_TAP_B  (LONG_TAP_B),
    .SHORT_TAP_A (SHORT_TAP_A),
    .SHORT_TAP_B (SHORT_TAP_B)
) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .mode_i   (mode_i),
    .taps_o   (taps_o),
    .period_o (period_o),
    .lock_o   (lock_o)
);

// File: tb/prbs15_xnor_gen_bench.sv
`timescale 1ns/1ps
module prbs15_xnor_gen_bench;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic        en_i  = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        prbs_o;
    logic [15:0] taps_o;
    logic        period_o;
    logic        lock_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [15:0] ref_q    = 16'h0000;
    logic        ref_mark = 1'b0;

    always #5 clk_i = ~clk_i;

    prbs15_xnor_gen u_prbs15_xnor_gen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .en_i     (en_i),
        .mode_i   (mode_i),
        .prbs_o   (prbs_o),
        .taps_o   (taps_o),
        .period_o (period_o),
        .lock_o   (lock_o)
    );

    function automatic logic [15:0] start_of(input logic [1:0] m);
        return (m == 2'b01) ? 16'hFFFF : 16'h0000;
    endfunction

    function automatic int span_of(input logic [1:0] m);
        return (m == 2'b01 || m == 2'b10) ? 4 : 15;
    endfunction

    function automatic logic same_span(input logic [15:0] a, input logic [15:0] b, input int n);
        for (int i = 0; i < n; i++) if (a[i] != b[i]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic stuck_of(input logic [15:0] q, input logic [1:0] m);
        return same_span(q, ~start_of(m), span_of(m));
    endfunction

    function automatic logic fb_of(input logic [15:0] q, input logic [1:0] m);
        if (m == 2'b01) return q[2] != q[3];
        if (m == 2'b10) return q[2] == q[3];
        return q[13] == q[14];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs at a falling edge, advance the model, compare after the rising edge.
    task automatic tick(input logic r, input logic e, input logic [1:0] m);
        logic [15:0] nq;
        rst_i = r; en_i = e; mode_i = m;
        if (r) begin
            ref_q = start_of(m); ref_mark = 1'b0;
        end else if (e) begin
            if (stuck_of(ref_q, m)) begin
                ref_q = start_of(m); ref_mark = 1'b0;
            end else begin
                nq = {ref_q[14:0], fb_of(ref_q, m)};
                ref_q = nq;
                ref_mark = same_span(nq, start_of(m), span_of(m));
            end
        end else begin
            ref_mark = 1'b0;
        end
        @(posedge clk_i);
        #1;
        chk((span_of(m) == 4) ? "R5 taps" : "R2 taps", {16'h0, taps_o}, {16'h0, ref_q});
        chk("R3 serial", {31'h0, prbs_o}, {31'h0, ref_q[13]});
        chk("R8 marker", {31'h0, period_o}, {31'h0, ref_mark});
        chk("R6 lock", {31'h0, lock_o}, {31'h0, stuck_of(ref_q, m)});
        @(negedge clk_i);
    endtask

    task automatic count_period(input logic [1:0] m, input int expect_n, input string req);
        int n = 0;
        tick(1'b1, 1'b0, m);
        do begin
            tick(1'b0, 1'b1, m);
            n++;
        end while (!period_o && n < 40000);
        chk(req, n, expect_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v = 32'd5081;
        void'($urandom(seed_v));
        @(negedge clk_i);

        // R1: reset state, long mode
        tick(1'b1, 1'b0, 2'b00);
        chk("R1 reset taps", {16'h0, taps_o}, 32'h0);
        chk("R1 reset marker", {31'h0, period_o}, 32'h0);

        // R2: first states from all zeros
        tick(1'b0, 1'b1, 2'b00);
        chk("R2 first step", {16'h0, taps_o}, 32'h0001);
        for (int i = 0; i < 13; i++) tick(1'b0, 1'b1, 2'b00);
        chk("R2 step 14", {16'h0, taps_o}, 32'h3FFF);
        chk("R3 serial high", {31'h0, prbs_o}, 32'h1);
        tick(1'b0, 1'b1, 2'b00);
        chk("R2 step 15", {16'h0, taps_o}, 32'h7FFE);

        // R9: hold with enable low
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 2'b00);
        chk("R9 hold", {16'h0, taps_o}, 32'h7FFE);

        // R4: full long period, then an idle edge clears the marker
        count_period(2'b00, 32767, "R4 long period");
        tick(1'b0, 1'b0, 2'b00);
        chk("R9 marker low on hold", {31'h0, period_o}, 32'h0);

        // R1 / R5: short XOR mode
        tick(1'b1, 1'b0, 2'b01);
        chk("R1 reset taps xor4", {16'h0, taps_o}, 32'hFFFF);
        tick(1'b0, 1'b1, 2'b01);
        chk("R5 xor4 first step", {16'h0, taps_o}, 32'hFFFE);
        count_period(2'b01, 15, "R5 xor4 period");
        count_period(2'b10, 15, "R5 xnor4 period");

        // R6 / R7: frozen pattern reached through a mode switch
        tick(1'b1, 1'b0, 2'b00);
        tick(1'b0, 1'b0, 2'b01);
        chk("R6 lock xor4", {31'h0, lock_o}, 32'h1);
        chk("R9 held while locked", {16'h0, taps_o}, 32'h0);
        tick(1'b0, 1'b1, 2'b01);
        chk("R7 recover xor4", {16'h0, taps_o}, 32'hFFFF);
        chk("R7 no marker", {31'h0, period_o}, 32'h0);
        chk("R7 lock cleared", {31'h0, lock_o}, 32'h0);

        tick(1'b1, 1'b0, 2'b01);
        tick(1'b0, 1'b0, 2'b10);
        chk("R6 lock xnor4", {31'h0, lock_o}, 32'h1);
        tick(1'b0, 1'b1, 2'b10);
        chk("R7 recover xnor4", {16'h0, taps_o}, 32'h0);
        chk("R7 no marker xnor4", {31'h0, period_o}, 32'h0);

        // Random mix of enables, mode switches and resets
        begin
            logic [1:0] m = 2'b00;
            for (int i = 0; i < 4000; i++) begin
                if (($urandom % 64) == 0) m = 2'($urandom % 4);
                tick((($urandom % 200) == 0), (($urandom % 4) != 0), m);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule